// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control and datapath core of a small 16-bit accumulator machine. It owns the program counter, the address register, the instruction register, a data register, the accumulator with its carry bit E, the latched addressing-mode bit and a slot counter. Each instruction runs as a chain of one-clock timing slots T0, T1, T2 and so on. T0 to T2 fetch and decode. T3 either chases an indirect pointer or hands a non-memory operation to an external unit. The memory-reference operations run from T4 onward. The slot counter returns to T0 as soon as an instruction completes, so short operations do not wait for a fixed frame.

The core drives a 12-bit word address and reads from a synchronous memory whose read data is valid in the same cycle as the address. Writes take effect on the clock edge that ends a cycle in which the write enable is high. Two strobes hand operations with opcode 7 to neighbouring units, together with the low twelve instruction bits. Those units may ask for the next instruction word to be skipped. The accumulator and E are brought out as outputs so that those units can test them. A run flag gates the slot counter. The start input sets the run flag, and the halt code clears it.

Top module: `acc_seq_core`

## Requirements
- R1: In reset and after it, `halted` is 1, `mem_we` and both strobes are 0, the accumulator is 0, and the first fetch after `start` reads address 0.
- R2: An instruction word has the indirect flag in bit 15, the opcode in bits 14..12 and the address in bits 11..0. Slot T0 puts the program counter on `mem_addr` for the T1 read. The program counter then advances by one, so the next instruction is fetched from the following word.
- R3: When the flag is 1 and the opcode is 0..6, the T3 slot reads the word at the instruction's address, and its bits 11..0 become the operand address used from T4 on. When the flag is 0, T3 does nothing. Both cases take the same number of cycles.
- R4: Opcode 0 ANDs the operand into the accumulator. Opcode 1 adds the operand and puts the carry-out into E. Opcode 2 loads the operand. Each takes 6 cycles.
- R5: Opcode 3 writes the accumulator to the operand address in T4 and takes 5 cycles.
- R6: Opcode 4 jumps to the operand address and takes 5 cycles.
- R7: Opcode 5 stores the return address (the word after the call) at the operand address and continues one word past that address. It takes 6 cycles.
- R8: Opcode 6 adds one to the memory word and writes it back. When the new value is zero, the next instruction is skipped. It takes 7 cycles.
- R9: Opcode 7 raises `reg_strobe` (flag 0) or `io_strobe` (flag 1) for exactly the T3 cycle, with `xop_bits` equal to instruction bits 11..0. When `skip_in` is 1 in that cycle, the next word is skipped. The instruction takes 4 cycles.
- R10: Opcode 7 with flag 0 and bit 0 set halts the core at the end of its T3 slot. While the core is halted and `start` is low, `halted` stays 1 and memory is neither written nor addressed differently.
- R11: `start` while the core is running has no effect on the result of the program.
- R12: The core never asserts `mem_we` in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sets the run flag |
| mem_rdata | input | 16 | Memory word at `mem_addr`, valid in the same cycle |
| skip_in | input | 1 | Skip request from the unit that takes an opcode 7 operation |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Data to write |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | Run flag is clear |
| acc_out | output | 16 | Accumulator |
| e_out | output | 1 | Carry bit E |
| reg_strobe | output | 1 | Register operation handed out (T3, flag 0) |
| io_strobe | output | 1 | I/O operation handed out (T3, flag 1) |
| xop_bits | output | 12 | Instruction bits 11..0 for the external units |

## Verification
The hardest case to reach is the increment-and-skip operation that wraps to zero. It must skip over a word the program would otherwise run, and it needs a memory word that holds all ones. The random programs therefore seed a quarter of the data words with 0xFFFF, place the halt code twice at the end so that a skip still lands on a halt, and mix direct and pointer-based operands. Each run is compared with an instruction-level model for the accumulator, E, the total cycle count and the whole memory image.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OP_W   = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_XOP = 3'd7
    } opcode_e;

    typedef struct packed {
        logic    ind;
        opcode_e op;
        addr_t   field;
    } instr_t;

    typedef struct packed {
        logic  carry;
        word_t val;
    } alu_res_t;

    // operations whose operand goes through the ALU in T5
    function automatic logic uses_alu(opcode_e op);
        return (op == OP_AND) || (op == OP_ADD) || (op == OP_LDA);
    endfunction

    // operations that load the data register in T4
    function automatic logic reads_operand(opcode_e op);
        return uses_alu(op) || (op == OP_ISZ);
    endfunction

endpackage

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
    parameter int NSLOT = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             clr,
    output logic             running,
    output logic [NSLOT-1:0] slot
);
    localparam int SCW = $clog2(NSLOT);

    logic           run_q;
    logic [SCW-1:0] sc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            sc_q  <= '0;
        end else begin
            if (stop)
                run_q <= 1'b0;
            else if (start)
                run_q <= 1'b1;
            if (clr || stop)
                sc_q <= '0;
            else if (run_q)
                sc_q <= sc_q + 1'b1;
        end
    end

    assign running = run_q;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot[g] = run_q && (sc_q == SCW'(g));
    end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
(
    input  opcode_e  op,
    input  word_t    ac,
    input  word_t    dr,
    input  logic     e_in,
    output alu_res_t res
);
    always_comb begin
        res.carry = e_in;
        res.val   = ac;
        case (op)
            OP_AND:  res.val = ac & dr;
            OP_ADD:  {res.carry, res.val} = {1'b0, ac} + {1'b0, dr};
            OP_LDA:  res.val = dr;
            default: res.val = ac;
        endcase
    end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int NSLOT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              skip_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halted,
    output logic [WORD_W-1:0] acc_out,
    output logic              e_out,
    output logic              reg_strobe,
    output logic              io_strobe,
    output logic [ADDR_W-1:0] xop_bits
);
    localparam int T_IND  = 3;
    localparam int T_EX0  = 4;
    localparam int T_EX1  = 5;
    localparam int T_EX2  = 6;

    addr_t    pc_q, ar_q;
    instr_t   ir_q;
    word_t    dr_q, ac_q;
    logic     e_q, ind_q;
    logic     running, stop, clr, xop_t3;
    logic [NSLOT-1:0] t;
    opcode_e  op;
    alu_res_t alu_res;

    assign op = ir_q.op;

    acc_seq_timer #(.NSLOT(NSLOT)) u_timer (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .clr(clr),
        .running(running), .slot(t)
    );

    acc_seq_alu u_alu (
        .op(op), .ac(ac_q), .dr(dr_q), .e_in(e_q), .res(alu_res)
    );

    assign xop_t3 = t[T_IND] && (op == OP_XOP);
    assign stop   = xop_t3 && !ind_q && ir_q.field[0];
    assign clr    = xop_t3
                 || (t[T_EX0] && (op == OP_STA || op == OP_BUN))
                 || (t[T_EX1] && (uses_alu(op) || op == OP_BSA))
                 || (t[T_EX2] && op == OP_ISZ);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ar_q  <= '0;
            ir_q  <= '0;
            dr_q  <= '0;
            ac_q  <= '0;
            e_q   <= 1'b0;
            ind_q <= 1'b0;
        end else begin
            if (t[0])
                ar_q <= pc_q;
            if (t[1]) begin
                ir_q <= instr_t'(mem_rdata);
                pc_q <= pc_q + 1'b1;
            end
            if (t[2]) begin
                ar_q  <= ir_q.field;
                ind_q <= ir_q.ind;
            end
            if (t[T_IND] && op != OP_XOP && ind_q)
                ar_q <= mem_rdata[ADDR_W-1:0];
            if (xop_t3 && skip_in)
                pc_q <= pc_q + 1'b1;
            if (t[T_EX0]) begin
                if (reads_operand(op))
                    dr_q <= mem_rdata;
                if (op == OP_BUN)
                    pc_q <= ar_q;
                if (op == OP_BSA)
                    ar_q <= ar_q + 1'b1;
            end
            if (t[T_EX1]) begin
                if (uses_alu(op)) begin
                    ac_q <= alu_res.val;
                    e_q  <= alu_res.carry;
                end
                if (op == OP_BSA)
                    pc_q <= ar_q;
                if (op == OP_ISZ)
                    dr_q <= dr_q + 1'b1;
            end
            if (t[T_EX2] && op == OP_ISZ && dr_q == '0)
                pc_q <= pc_q + 1'b1;
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = ac_q;
        if (t[T_EX0] && op == OP_STA) begin
            mem_we = 1'b1;
        end else if (t[T_EX0] && op == OP_BSA) begin
            mem_we    = 1'b1;
            mem_wdata = word_t'(pc_q);
        end else if (t[T_EX2] && op == OP_ISZ) begin
            mem_we    = 1'b1;
            mem_wdata = dr_q;
        end
    end

    assign mem_addr   = ar_q;
    assign halted     = !running;
    assign acc_out    = ac_q;
    assign e_out      = e_q;
    assign reg_strobe = xop_t3 && !ind_q;
    assign io_strobe  = xop_t3 && ind_q;
    assign xop_bits   = ir_q.field;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              halted,
    input logic              mem_we,
    input logic              reg_strobe,
    input logic              io_strobe,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r1_halted_after_reset: assert property (@(posedge clk)
        rst |=> halted);

    a_r1_quiet_when_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !reg_strobe && !io_strobe));

    a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_strobe && io_strobe));

    a_r9_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (reg_strobe || io_strobe) |=> !(reg_strobe || io_strobe));

    a_r10_stay_halted: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> halted);

    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> $stable(mem_addr));

    a_r11_start_runs: assert property (@(posedge clk) disable iff (rst)
        (halted && start) |=> !halted);

    a_r12_no_back_to_back_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
endmodule

bind acc_seq_core acc_seq_chk #(.ADDR_W(acc_seq_pkg::ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .halted(halted), .mem_we(mem_we),
    .reg_strobe(reg_strobe), .io_strobe(io_strobe), .mem_addr(mem_addr)
);

// File: tb/acc_seq_core_bench.sv
module acc_seq_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] mem_rdata;
    logic        skip_in;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we, halted, e_out, reg_strobe, io_strobe;
    logic [15:0] acc_out;
    logic [11:0] xop_bits;

    logic [15:0] mem [0:255];
    logic [15:0] ref_mem [0:255];
    logic [11:0] trace [0:63];
    logic        skip_en = 1'b0;
    int total = 0, fails = 0, cyc = 0;
    int n_reg = 0, n_io = 0, halted_writes = 0;
    logic [11:0] last_io_bits = '0;

    int          m_cyc, m_reg, m_io;
    logic [15:0] m_ac;
    logic        m_e;

    always #4 clk = ~clk;

    acc_seq_core u_acc_seq_core (
        .clk(clk), .rst(rst), .start(start), .mem_rdata(mem_rdata), .skip_in(skip_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted),
        .acc_out(acc_out), .e_out(e_out), .reg_strobe(reg_strobe), .io_strobe(io_strobe),
        .xop_bits(xop_bits)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    assign skip_in   = skip_en && (reg_strobe || io_strobe);

    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    always @(negedge clk) begin
        if (!rst && reg_strobe) n_reg++;
        if (!rst && io_strobe) begin n_io++; last_io_bits = xop_bits; end
        if (!rst && halted && mem_we) halted_writes++;
    end

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // instruction-level model, independent of slot timing
    task automatic model_run(input bit skp);
        logic [11:0] pc = '0;
        m_ac = '0; m_e = 1'b0; m_cyc = 0; m_reg = 0; m_io = 0;
        for (int s = 0; s < 600; s++) begin
            logic [15:0] w, v;
            logic [11:0] a;
            logic [2:0]  op;
            w  = ref_mem[pc[7:0]];
            pc = pc + 1;
            op = w[14:12];
            a  = w[11:0];
            if (op == 3'd7) begin
                m_cyc += 4;
                if (w[15]) m_io++; else m_reg++;
                if (skp) pc = pc + 1;
                if (!w[15] && w[0]) break;
            end else begin
                if (w[15]) a = ref_mem[a[7:0]][11:0];
                case (op)
                    3'd0: begin m_ac = m_ac & ref_mem[a[7:0]]; m_cyc += 6; end
                    3'd1: begin {m_e, m_ac} = {1'b0, m_ac} + {1'b0, ref_mem[a[7:0]]}; m_cyc += 6; end
                    3'd2: begin m_ac = ref_mem[a[7:0]]; m_cyc += 6; end
                    3'd3: begin ref_mem[a[7:0]] = m_ac; m_cyc += 5; end
                    3'd4: begin pc = a; m_cyc += 5; end
                    3'd5: begin ref_mem[a[7:0]] = {4'h0, pc}; pc = a + 1; m_cyc += 6; end
                    default: begin
                        v = ref_mem[a[7:0]] + 1;
                        ref_mem[a[7:0]] = v;
                        if (v == 16'h0000) pc = pc + 1;
                        m_cyc += 7;
                    end
                endcase
            end
        end
    endtask

    task automatic do_reset(input bit check);
        @(negedge clk); rst = 1'b1; start = 1'b0;
        @(negedge clk);
        if (check) begin
            chk("R1", "halted in reset", halted, 1);
            chk("R1", "mem_we in reset", mem_we, 0);
            chk("R1", "strobes in reset", {reg_strobe, io_strobe}, 0);
        end
        @(negedge clk); rst = 1'b0;
        if (check) chk("R1", "acc after reset", acc_out, 0);
    endtask

    task automatic run_prog(input string req, input bit skp, input bit mid_start);
        int cnt = 0, bad = 0;
        for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
        model_run(skp);
        do_reset(1'b0);
        skip_en = skp;
        n_reg = 0; n_io = 0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        trace[0] = mem_addr;
        while (!halted && cnt < 4000) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            start = (mid_start && cnt == 3);
            if (cnt < 64) trace[cnt] = mem_addr;
        end
        start = 1'b0;
        chk(req, "cycle count", cnt, m_cyc);
        chk(req, "accumulator", acc_out, m_ac);
        chk(req, "carry E", e_out, m_e);
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(req, "memory words differing", bad, 0);
    endtask

    initial begin
        clear_mem();
        do_reset(1'b1);

        // R2/R3: fetch addresses and pointer chase
        clear_mem();
        mem[0] = 16'hA031; mem[1] = 16'h3040; mem[2] = 16'h7001;
        mem[8'h31] = 16'h0032; mem[8'h32] = 16'h5555;
        run_prog("R3", 1'b0, 1'b0);
        chk("R2", "first fetch address", trace[1], 12'h000);
        chk("R2", "second fetch address", trace[7], 12'h001);
        chk("R3", "pointer address in T3", trace[3], 12'h031);
        chk("R3", "operand address in T4", trace[4], 12'h032);
        chk("R5", "stored word", mem[8'h40], 16'h5555);

        // R4: add with carry out
        clear_mem();
        mem[0] = 16'h2030; mem[1] = 16'h1031; mem[2] = 16'h0032; mem[3] = 16'h7001;
        mem[8'h30] = 16'hFFFF; mem[8'h31] = 16'h0003; mem[8'h32] = 16'h00F6;
        run_prog("R4", 1'b0, 1'b0);
        chk("R4", "AND after ADD", acc_out, 16'h0002);
        chk("R4", "carry out of ADD", e_out, 1);

        // R6/R7: call, load, indirect return
        clear_mem();
        mem[0] = 16'h5020; mem[1] = 16'h7001;
        mem[8'h21] = 16'h2030; mem[8'h22] = 16'hC020; mem[8'h30] = 16'h1234;
        run_prog("R7", 1'b0, 1'b0);
        chk("R7", "saved return address", mem[8'h20], 16'h0001);
        chk("R6", "returned and loaded", acc_out, 16'h1234);

        // R8: wrap to zero skips, no wrap does not
        clear_mem();
        mem[0] = 16'h6040; mem[1] = 16'h7001; mem[2] = 16'h2041; mem[3] = 16'h7001;
        mem[8'h40] = 16'hFFFF; mem[8'h41] = 16'hABCD;
        run_prog("R8", 1'b0, 1'b0);
        chk("R8", "skip taken", acc_out, 16'hABCD);
        chk("R8", "wrapped word", mem[8'h40], 16'h0000);
        clear_mem();
        mem[0] = 16'h6040; mem[1] = 16'h7001; mem[2] = 16'h2041; mem[3] = 16'h7001;
        mem[8'h40] = 16'h0005; mem[8'h41] = 16'hABCD;
        run_prog("R8", 1'b0, 1'b0);
        chk("R8", "no skip", acc_out, 16'h0000);
        chk("R8", "incremented word", mem[8'h40], 16'h0006);

        // R9: hand-off strobes with skip requests
        clear_mem();
        mem[0] = 16'h7020; mem[1] = 16'h7001; mem[2] = 16'hF080; mem[3] = 16'h7001;
        mem[4] = 16'h2030; mem[5] = 16'h7001; mem[8'h30] = 16'h0BAD;
        run_prog("R9", 1'b1, 1'b0);
        chk("R9", "register strobes", n_reg, m_reg);
        chk("R9", "io strobes", n_io, 1);
        chk("R9", "io bits", last_io_bits, 12'h080);
        chk("R9", "skips followed", acc_out, 16'h0BAD);

        // R10: stays halted without start
        repeat (12) @(negedge clk);
        chk("R10", "still halted", halted, 1);
        chk("R10", "writes while halted", halted_writes, 0);
        chk("R10", "memory untouched", mem[8'h30], 16'h0BAD);

        // R11: start pulse while running
        clear_mem();
        mem[0] = 16'h2030; mem[1] = 16'h1031; mem[2] = 16'h3032; mem[3] = 16'h7001;
        mem[8'h30] = 16'h1111; mem[8'h31] = 16'h2222;
        run_prog("R11", 1'b0, 1'b1);
        chk("R11", "result word", mem[8'h32], 16'h3333);

        // random straight-line programs, R4 R5 R8 R3 R12
        void'($urandom(32'd2024));
        for (int p = 0; p < 40; p++) begin
            int len;
            clear_mem();
            len = 5 + ($urandom % 30);
            for (int i = 0; i < len; i++) begin
                logic [2:0] ops [5];
                logic [2:0] o;
                logic ind;
                logic [3:0] k;
                ops = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6};
                o   = ops[$urandom % 5];
                ind = $urandom % 2;
                k   = 4'($urandom % 16);
                mem[i] = {ind, o, ind ? {8'h09, k} : {8'h08, k}};
            end
            mem[len] = 16'h7001; mem[len + 1] = 16'h7001;
            for (int k = 0; k < 16; k++) begin
                mem[8'h80 + k] = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
                mem[8'h90 + k] = {8'h00, 4'h8, 4'($urandom % 16)};
            end
            run_prog("R8", 1'b0, 1'b0);
        end
        chk("R12", "writes while halted overall", halted_writes, 0);

        finish_up();
    end
endmodule